// File: doc/BRIEF.md
# Masked Substitution Table Reconfigurator

This block keeps a 256-entry, 8-bit substitution table whose contents are randomized for each encryption, together with the sweep logic that rewrites it. A start pulse captures an 8-bit input mask and an 8-bit output mask. A counter then walks every physical table address `a` and stores `S(a ^ m) ^ n` there, where `S` is the AES S-box. After the sweep, each location `x ^ m` holds `S(x) ^ n`. The S-box function is built into the block.

The read port takes a masked byte and returns a masked byte. The read path never carries the plain value or either mask. The parameter `WR_BITS` (1, 4 or 8) sets how many entries are written in each sweep cycle, so a rewrite takes 256, 64 or 32 cycles. The parameter `READ_LAT` (0, 1 or 2) selects one of three read styles: a combinational read, a registered read, or a registered read with an extra output register. A cipher datapath starts the sweep, waits for the done pulse, and then uses the table for the whole encryption.

Top module: `masked_sbox_tbl`

## Requirements
- R1: While and just after reset, `busy_o` and `done_o` are 0.
- R2: After a completed sweep started with masks `m` and `n`, reading address `x ^ m` returns `S(x) ^ n` for every `x` in 0..255, where `S` is the AES S-box.
- R3: On the clock edge that samples `start_i` high while idle, `busy_o` rises. It stays high for exactly 256/`WR_BITS` cycles, which is 64 at the default `WR_BITS`=4.
- R4: `done_o` is high for exactly one cycle. That cycle directly follows the last busy cycle, and `busy_o` is low during it.
- R5: The masks are captured only by an accepted start. A start pulse or a change on the mask inputs during a sweep has no effect: the sweep length is unchanged and the final table reflects the captured masks.
- R6: Read data is available `READ_LAT` clock edges after the address is presented. With `READ_LAT`=0 the read is combinational.
- R7: With `WR_BITS`=1 a sweep lasts 256 cycles, and with `WR_BITS`=8 it lasts 32 cycles.
- R8: With both masks zero, the table equals the plain S-box at every address.
- R9: A later sweep with new masks replaces every entry of the previous table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a rewrite; accepted only while idle |
| in_mask_i | input | 8 | Input mask m, captured at start |
| out_mask_i | input | 8 | Output mask n, captured at start |
| busy_o | output | 1 | Rewrite in progress |
| done_o | output | 1 | One-cycle pulse after the last write |
| rd_addr_i | input | 8 | Masked table index |
| rd_data_o | output | 8 | Masked table output |

## Verification
If the address counter skips a value, or the masks are recaptured partway through a sweep, stale or wrongly masked entries stay in the table. These errors show only when the affected addresses are read after the done pulse, so the bench reads all 256 entries after every sweep. A fault in the counter limit or in the done logic shows at once as a wrong busy length or a missing or doubled done pulse, which the bench counts cycle by cycle. A read-latency fault shows on the first read after the sweep.

// File: rtl/sbox_tbl_pkg.sv
package sbox_tbl_pkg;

  localparam int unsigned TBL_DEPTH = 256;
  localparam int unsigned DW        = 8;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] p;
    r = '0;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ p;
      p = p[7] ? ((p << 1) ^ 8'h1b) : (p << 1);
    end
    return r;
  endfunction

  // a^254 = a^2 * a^4 * ... * a^128
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = gf_mul(a, a);
    r  = sq;
    for (int i = 0; i < 6; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] aes_sbox(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/sbox_cfg_gen.sv
module sbox_cfg_gen
  import sbox_tbl_pkg::*;
#(
  parameter int unsigned WR_BITS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [7:0]            in_mask_i,
  input  logic [7:0]            out_mask_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  wr_en_o,
  output logic [7:0]            wr_base_o,
  output logic [WR_BITS*DW-1:0] wr_data_o
);

  localparam int unsigned N_CYC = TBL_DEPTH / WR_BITS;
  localparam int unsigned CW    = $clog2(N_CYC);

  logic [CW-1:0] cnt_q;
  logic [7:0]    m_q, n_q;
  logic          busy_q, done_q;
  logic          last;

  assign last = (cnt_q == CW'(N_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      m_q    <= '0;
      n_q    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && last;
      if (!busy_q) begin
        if (start_i) begin
          m_q    <= in_mask_i;
          n_q    <= out_mask_i;
          cnt_q  <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign wr_en_o   = busy_q;
  assign wr_base_o = 8'(32'(cnt_q) * WR_BITS);

  // one content generator per entry written in a cycle
  for (genvar k = 0; k < WR_BITS; k++) begin : g_lane
    logic [7:0] phys;
    assign phys = wr_base_o + 8'(k);
    assign wr_data_o[k*DW +: DW] = aes_sbox(phys ^ m_q) ^ n_q;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                   // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));                  // R4
  AST_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(m_q) && $stable(n_q)); // R5
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last |=> busy_o && cnt_q == $past(cnt_q) + 1'b1); // R3
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && cnt_q == '0);         // R3

endmodule

// File: rtl/sbox_tbl_mem.sv
module sbox_tbl_mem
  import sbox_tbl_pkg::*;
#(
  parameter int unsigned WR_BITS  = 4,
  parameter int unsigned READ_LAT = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_base_i,
  input  logic [WR_BITS*DW-1:0] wr_data_i,
  input  logic [7:0]            rd_addr_i,
  output logic [7:0]            rd_data_o
);

  logic [7:0] tbl_q [TBL_DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int k = 0; k < WR_BITS; k++) begin
        tbl_q[wr_base_i + 8'(k)] <= wr_data_i[k*DW +: DW];
      end
    end
  end

  if (READ_LAT == 0) begin : g_async
    assign rd_data_o = tbl_q[rd_addr_i];
  end else begin : g_sync
    logic [7:0] rd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_q <= '0;
      else         rd_q <= tbl_q[rd_addr_i];
    end
    if (READ_LAT == 1) begin : g_one
      assign rd_data_o = rd_q;
    end else begin : g_two
      logic [7:0] out_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= rd_q;
      end
      assign rd_data_o = out_q;
      AST_OUT_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ##1 rd_data_o == $past(rd_q));                     // R6
    end
  end

endmodule

// File: rtl/masked_sbox_tbl.sv
module masked_sbox_tbl
  import sbox_tbl_pkg::*;
#(
  parameter int unsigned WR_BITS  = 4,
  parameter int unsigned READ_LAT = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] in_mask_i,
  input  logic [7:0] out_mask_i,
  output logic       busy_o,
  output logic       done_o,
  input  logic [7:0] rd_addr_i,
  output logic [7:0] rd_data_o
);

  logic                  wr_en;
  logic [7:0]            wr_base;
  logic [WR_BITS*DW-1:0] wr_data;

  sbox_cfg_gen #(.WR_BITS(WR_BITS)) i_cfg_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .in_mask_i  (in_mask_i),
    .out_mask_i (out_mask_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .wr_en_o    (wr_en),
    .wr_base_o  (wr_base),
    .wr_data_o  (wr_data)
  );

  sbox_tbl_mem #(.WR_BITS(WR_BITS), .READ_LAT(READ_LAT)) i_tbl_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_base_i (wr_base),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !busy_o && !done_o);                 // R1

endmodule

// File: tb/test_masked_sbox_tbl.sv
module test_masked_sbox_tbl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] m_in = '0, n_in = '0, rd_addr = '0;
  logic [2:0] busy, done;
  logic [7:0] rd0, rd1, rd2;
  int checks = 0, fails = 0;
  logic [7:0] ref_s [256];

  always #2 clk = ~clk;

  // default instance: 4 entries per cycle, registered read
  masked_sbox_tbl i_masked_sbox_tbl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .in_mask_i(m_in), .out_mask_i(n_in),
    .busy_o(busy[1]), .done_o(done[1]), .rd_addr_i(rd_addr), .rd_data_o(rd1));

  masked_sbox_tbl #(.WR_BITS(1), .READ_LAT(0)) i_masked_sbox_tbl_w1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .in_mask_i(m_in), .out_mask_i(n_in),
    .busy_o(busy[0]), .done_o(done[0]), .rd_addr_i(rd_addr), .rd_data_o(rd0));

  masked_sbox_tbl #(.WR_BITS(8), .READ_LAT(2)) i_masked_sbox_tbl_w8 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .in_mask_i(m_in), .out_mask_i(n_in),
    .busy_o(busy[2]), .done_o(done[2]), .rd_addr_i(rd_addr), .rd_data_o(rd2));

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    for (int i = 7; i >= 0; i--) begin
      r = r[7] ? ((r << 1) ^ 8'h1b) : (r << 1);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic build_ref();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 0;
      logic [7:0] y;
      for (int c = 1; c < 256; c++) if (mul(8'(x), 8'(c)) == 8'h01) inv = 8'(c);
      y = 8'h63;
      for (int b = 0; b < 8; b++)
        y[b] = y[b] ^ inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8];
      ref_s[x] = y;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // start a sweep; optionally disturb it halfway (R5); measure busy length and done
  task automatic sweep(input logic [7:0] m, input logic [7:0] n, input bit disturb, input string req);
    int bcnt [3];
    int dcnt [3];
    int didx [3];
    for (int i = 0; i < 3; i++) begin bcnt[i] = 0; dcnt[i] = 0; didx[i] = -1; end
    @(negedge clk); start = 1'b1; m_in = m; n_in = n;
    @(negedge clk); start = 1'b0;
    for (int j = 0; j < 260; j++) begin
      for (int i = 0; i < 3; i++) begin
        if (busy[i]) bcnt[i]++;
        if (done[i]) begin dcnt[i]++; didx[i] = j; chk("R4 busy low with done", int'(busy[i]), 0); end
      end
      if (disturb && j == 10) begin start = 1'b1; m_in = ~m; n_in = ~n; end
      if (disturb && j == 11) start = 1'b0;
      @(negedge clk);
    end
    chk({req, " R7 sweep len w1"}, bcnt[0], 256);
    chk({req, " R3 sweep len w4"}, bcnt[1], 64);
    chk({req, " R7 sweep len w8"}, bcnt[2], 32);
    chk({req, " R4 done count w1"}, dcnt[0], 1);
    chk({req, " R4 done count w4"}, dcnt[1], 1);
    chk({req, " R4 done count w8"}, dcnt[2], 1);
    chk({req, " R4 done position w4"}, didx[1], 64);
    chk({req, " R4 done position w8"}, didx[2], 32);
  endtask

  // read all entries at the three latencies (R6) and compare with S(x)^n (R2)
  task automatic read_all(input logic [7:0] m, input logic [7:0] n, input string req);
    int bad [3];
    for (int i = 0; i < 3; i++) bad[i] = 0;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] e;
      e = ref_s[x] ^ n;
      rd_addr = 8'(x) ^ m;
      #1;
      if (rd0 != e) bad[0]++;
      @(negedge clk);
      if (rd1 != e) bad[1]++;
      @(negedge clk);
      if (rd2 != e) bad[2]++;
    end
    chk({req, " R6 lat0 mismatches"}, bad[0], 0);
    chk({req, " R6 lat1 mismatches"}, bad[1], 0);
    chk({req, " R6 lat2 mismatches"}, bad[2], 0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      chk("R1 busy at reset", int'(busy[i]), 0);
      chk("R1 done at reset", int'(done[i]), 0);
    end
  endtask

  task automatic t_plain();
    sweep(8'h00, 8'h00, 1'b0, "R8");
    read_all(8'h00, 8'h00, "R8 plain");
  endtask

  task automatic t_masked();
    sweep(8'h5a, 8'hc3, 1'b0, "R2");
    read_all(8'h5a, 8'hc3, "R2 masked");
  endtask

  task automatic t_replace();
    sweep(8'h81, 8'h1f, 1'b0, "R9");
    read_all(8'h81, 8'h1f, "R9 replaced");
  endtask

  task automatic t_hold();
    sweep(8'h37, 8'he4, 1'b1, "R5");
    read_all(8'h37, 8'he4, "R5 held masks");
  endtask

  initial begin
    build_ref();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_masked();
    t_replace();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule